// File: doc/BRIEF.md
# Dual-Channel Select-Qualified Sample Capture

The block takes a shared sample bus (a data word plus a small exponent field) and a single select line. The select line has two jobs. It names the logical channel on the bus, and it also acts as the input enable. A sample is latched only on a clock where the select level differs from the level seen on the clock before. While the level holds, later bus values are ignored. Each accepted sample leaves the block on registered outputs: a one-clock valid strobe, a channel tag and the captured word with its exponent.

The same edge rule serves both a full-rate source, where the select line toggles every clock, and a slower source, where each level lasts several clocks. A complex mode can also be enabled. In that mode a high select carries an in-phase sample and a low select carries a quadrature sample. Each quadrature sample is joined to the in-phase sample held from the capture just before it, and the two are emitted together as a pair. A quadrature sample with no in-phase partner is thrown away, and a sticky error flag records the event.

Top module: `dual_strobe_capture`

## Requirements
- R1: While `rst` is high, and on the first clock edge after `rst` falls, no sample is accepted, whatever the select level. After reset, every output reads zero.
- R2: When `sel` at a clock edge differs from its value at the previous edge (after the first edge following reset), the `din`/`ein` present at that edge appear on `out_data`/`out_exp` after that edge, and `out_valid` is high for exactly that one clock.
- R3: `out_chan` is the `sel` level of the accepting edge: 1 means channel A or in-phase, 0 means channel B or quadrature.
- R4: While `sel` holds its level, no sample is accepted, `out_valid` stays low, and `out_data`/`out_exp` keep their last captured values even if the bus changes.
- R5: When `sel` toggles on every clock, a sample is accepted on every clock.
- R6: With `cplx_en` high, accepting a low-select sample while an in-phase sample is held drives `pair_valid` high for one clock. `pair_i`/`pair_i_exp` then carry the held in-phase word, and `pair_q`/`pair_q_exp` carry the new word. This happens in the same clock as its `out_valid`.
- R7: With `cplx_en` high, a low-select transition while no in-phase sample is held produces no `out_valid` and no `pair_valid`, and it sets `iq_err`.
- R8: A clock with `cplx_en` low discards any held in-phase sample.
- R9: Once set, `iq_err` stays high until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| cplx_en | input | 1 | 1 selects complex I/Q pairing |
| sel | input | 1 | Channel select and capture qualifier |
| din | input | DATA_W | Sample data word |
| ein | input | EXP_W | Sample exponent |
| out_valid | output | 1 | One-clock strobe per accepted sample |
| out_chan | output | 1 | Channel tag of the accepted sample |
| out_data | output | DATA_W | Captured data word |
| out_exp | output | EXP_W | Captured exponent |
| pair_valid | output | 1 | One-clock strobe per complete I/Q pair |
| pair_i | output | DATA_W | In-phase word of the pair |
| pair_i_exp | output | EXP_W | In-phase exponent of the pair |
| pair_q | output | DATA_W | Quadrature word of the pair |
| pair_q_exp | output | EXP_W | Quadrature exponent of the pair |
| iq_err | output | 1 | Sticky unpaired-quadrature flag |

## Verification
The assertions assume that `rst` is held high from time zero and that all inputs are stable and known around each rising edge. They also assume that `cplx_en` changes only between edges, like any other input. The stimulus drives every input on the falling edge. It starts from reset and keeps each level of `sel` for whole clocks: one clock in the full-rate phases, three clocks in the slow phases, and long runs in the hold phase. The data bus changes every clock, so stale captures and unqualified captures show up in the compare.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
  localparam int DCAP_DATA_W = 16;
  localparam int DCAP_EXP_W  = 3;
  localparam logic SEL_IPHASE = 1'b1;
  localparam logic SEL_QUAD   = 1'b0;
endpackage

// File: rtl/sel_track.sv
module sel_track (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  output logic cap
);
  logic armed_q;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      sel_q   <= sel;
    end
  end

  assign cap = armed_q && (sel != sel_q);

  // R1
  first_edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cap);
endmodule

// File: rtl/sample_latch.sv
module sample_latch #(
  parameter int DATA_W = dcap_pkg::DCAP_DATA_W,
  parameter int EXP_W  = dcap_pkg::DCAP_EXP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              chan,
  input  logic [DATA_W-1:0] din,
  input  logic [EXP_W-1:0]  ein,
  output logic              out_valid,
  output logic              out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic [EXP_W-1:0]  out_exp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
      out_data  <= '0;
      out_exp   <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_chan <= chan;
        out_data <= din;
        out_exp  <= ein;
      end
    end
  end

  // R4
  idle_holds_word_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data) || $past(rst));
endmodule

// File: rtl/iq_pair.sv
module iq_pair #(
  parameter int DATA_W = dcap_pkg::DCAP_DATA_W,
  parameter int EXP_W  = dcap_pkg::DCAP_EXP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cplx,
  input  logic              cap,
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  input  logic [EXP_W-1:0]  ein,
  output logic              drop,
  output logic              pair_valid,
  output logic [DATA_W-1:0] pair_i,
  output logic [EXP_W-1:0]  pair_i_exp,
  output logic [DATA_W-1:0] pair_q,
  output logic [EXP_W-1:0]  pair_q_exp,
  output logic              err
);
  import dcap_pkg::*;

  logic              pend_q;
  logic [DATA_W-1:0] hold_d;
  logic [EXP_W-1:0]  hold_e;
  logic              is_i;
  logic              is_q;

  assign is_i = cplx && cap && (sel == SEL_IPHASE);
  assign is_q = cplx && cap && (sel == SEL_QUAD);
  assign drop = is_q && !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      hold_d     <= '0;
      hold_e     <= '0;
      pair_valid <= 1'b0;
      pair_i     <= '0;
      pair_i_exp <= '0;
      pair_q     <= '0;
      pair_q_exp <= '0;
      err        <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (!cplx) begin
        pend_q <= 1'b0;
      end else if (is_i) begin
        hold_d <= din;
        hold_e <= ein;
        pend_q <= 1'b1;
      end else if (is_q) begin
        if (pend_q) begin
          pair_valid <= 1'b1;
          pair_i     <= hold_d;
          pair_i_exp <= hold_e;
          pair_q     <= din;
          pair_q_exp <= ein;
          pend_q     <= 1'b0;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  // R7
  orphan_q_flags_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> err && !pair_valid);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/dual_strobe_capture.sv
module dual_strobe_capture #(
  parameter int DATA_W = dcap_pkg::DCAP_DATA_W,
  parameter int EXP_W  = dcap_pkg::DCAP_EXP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cplx_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  input  logic [EXP_W-1:0]  ein,
  output logic              out_valid,
  output logic              out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic [EXP_W-1:0]  out_exp,
  output logic              pair_valid,
  output logic [DATA_W-1:0] pair_i,
  output logic [EXP_W-1:0]  pair_i_exp,
  output logic [DATA_W-1:0] pair_q,
  output logic [EXP_W-1:0]  pair_q_exp,
  output logic              iq_err
);
  logic cap;
  logic drop;
  logic take;

  sel_track u_track (
    .clk (clk),
    .rst (rst),
    .sel (sel),
    .cap (cap)
  );

  iq_pair #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_pair (
    .clk        (clk),
    .rst        (rst),
    .cplx       (cplx_en),
    .cap        (cap),
    .sel        (sel),
    .din        (din),
    .ein        (ein),
    .drop       (drop),
    .pair_valid (pair_valid),
    .pair_i     (pair_i),
    .pair_i_exp (pair_i_exp),
    .pair_q     (pair_q),
    .pair_q_exp (pair_q_exp),
    .err        (iq_err)
  );

  assign take = cap && !drop;

  sample_latch #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .chan      (sel),
    .din       (din),
    .ein       (ein),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data),
    .out_exp   (out_exp)
  );

  // R3
  tag_matches_sel_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_chan == $past(sel));

  // R4
  held_sel_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == $past(sel)) |=> !out_valid);

  // R6
  pair_with_quad_chk: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> out_valid && !out_chan && out_data == pair_q);
endmodule

// File: tb/dual_strobe_capture_tb_top.sv
module dual_strobe_capture_tb_top;
  localparam int DW = 16;
  localparam int EW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cplx_en = 1'b0;
  logic sel = 1'b0;
  logic [DW-1:0] din = '0;
  logic [EW-1:0] ein = '0;
  logic out_valid, out_chan, pair_valid, iq_err;
  logic [DW-1:0] out_data, pair_i, pair_q;
  logic [EW-1:0] out_exp, pair_i_exp, pair_q_exp;

  dual_strobe_capture #(.DATA_W(DW), .EXP_W(EW)) dut_i (
    .clk(clk), .rst(rst), .cplx_en(cplx_en), .sel(sel), .din(din), .ein(ein),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data), .out_exp(out_exp),
    .pair_valid(pair_valid), .pair_i(pair_i), .pair_i_exp(pair_i_exp),
    .pair_q(pair_q), .pair_q_exp(pair_q_exp), .iq_err(iq_err)
  );

  always #5 clk = ~clk;

  int vecs = 0;
  int bad = 0;
  bit done = 1'b0;
  string phase = "R1";

  // reference model state
  bit m_armed = 0;
  bit m_prev = 0;
  bit m_err = 0;
  logic [DW+EW-1:0] held_q[$];
  bit e_valid = 0, e_chan = 0, e_pv = 0;
  logic [DW-1:0] e_data = '0, e_pi = '0, e_pq = '0;
  logic [EW-1:0] e_exp = '0, e_pie = '0, e_pqe = '0;

  task automatic model_step();
    bit cap, take;
    logic [DW+EW-1:0] h;
    if (rst) begin
      m_armed = 0; m_prev = 0; m_err = 0; held_q.delete();
      e_valid = 0; e_chan = 0; e_pv = 0;
      e_data = '0; e_exp = '0; e_pi = '0; e_pq = '0; e_pie = '0; e_pqe = '0;
    end else begin
      cap = m_armed && (sel != m_prev);
      take = cap;
      e_pv = 0;
      if (!cplx_en) held_q.delete();
      else if (cap) begin
        if (sel) begin
          held_q.delete();
          held_q.push_back({ein, din});
        end else if (held_q.size() > 0) begin
          h = held_q.pop_front();
          e_pv = 1; e_pi = h[DW-1:0]; e_pie = h[DW+EW-1:DW];
          e_pq = din; e_pqe = ein;
        end else begin
          m_err = 1; take = 0;
        end
      end
      e_valid = take;
      if (take) begin e_chan = sel; e_data = din; e_exp = ein; end
      m_armed = 1; m_prev = sel;
    end
  endtask

  task automatic check(string what, string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t", tag, phase, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit r, bit c, bit s);
    @(negedge clk);
    rst = r; cplx_en = c; sel = s;
    din = DW'($urandom); ein = EW'($urandom);
    @(posedge clk);
    model_step();
    #1;
    check("out_valid", "R2", 32'(out_valid), 32'(e_valid));
    check("out_chan", "R3", 32'(out_chan), 32'(e_chan));
    check("out_data", "R2", 32'(out_data), 32'(e_data));
    check("out_exp", "R2", 32'(out_exp), 32'(e_exp));
    check("pair_valid", "R6", 32'(pair_valid), 32'(e_pv));
    check("pair_i", "R6", 32'(pair_i), 32'(e_pi));
    check("pair_i_exp", "R6", 32'(pair_i_exp), 32'(e_pie));
    check("pair_q", "R6", 32'(pair_q), 32'(e_pq));
    check("pair_q_exp", "R6", 32'(pair_q_exp), 32'(e_pqe));
    check("iq_err", "R7", 32'(iq_err), 32'(m_err));
  endtask

  initial begin
    // R1: reset, then a select change on the very first clock after reset
    phase = "R1";
    for (int i = 0; i < 3; i++) cyc(1, 0, i[0]);
    cyc(0, 0, 1);
    cyc(0, 0, 1);
    // R5: full-rate toggling, real mode
    phase = "R5";
    for (int i = 0; i < 20; i++) cyc(0, 0, i[0]);
    // R2/R4: slow source, three clocks per level
    phase = "R4";
    for (int i = 0; i < 24; i++) cyc(0, 0, (i / 3) % 2 == 1);
    // R4: long hold with changing bus
    for (int i = 0; i < 10; i++) cyc(0, 0, 1);
    // R7: complex mode, first transition lands on quadrature
    phase = "R7";
    cyc(0, 1, 0);
    // R6: complex full-rate pairing
    phase = "R6";
    for (int i = 0; i < 20; i++) cyc(0, 1, !i[0]);
    for (int i = 0; i < 18; i++) cyc(0, 1, (i / 3) % 2 == 0);
    // R9: error stays through more traffic
    phase = "R9";
    for (int i = 0; i < 6; i++) cyc(0, 0, i[0]);
    cyc(1, 0, 0);
    cyc(1, 0, 0);
    // R8: held in-phase discarded by leaving complex mode
    phase = "R8";
    cyc(0, 1, 0);
    cyc(0, 1, 0);
    cyc(0, 1, 1);
    cyc(0, 0, 1);
    cyc(0, 1, 0);
    for (int i = 0; i < 8; i++) cyc(0, 1, !i[0]);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule